// File: doc/BRIEF.md
# Frame Parameter and Packet Intake Controller

This block sits at the entrance of a block-coded frame processor and decides what reaches the coding datapath. It runs two handshakes toward the upstream source, one for configuration sets and one for packet beats. Both have a ready latency of one cycle: a valid counts only when the matching ready was high in the cycle before. A configuration set carries a code length code, a CRC selection, an interleave flag and a 16-bit identifier used for CRC masking. The block checks the set, keeps it in a staging register, and copies it to the active register when a frame starts. A frame that arrives with no fresh configuration reuses the last legal set.

Each accepted beat is passed to the datapath one cycle later with a beat index, a frame-start strobe and a last-beat flag. Several beats are dropped on purpose: the beat right after a configuration write, the beat right after a frame end, and a beat that arrives together with a configuration write. The datapath ends a frame with a done pulse. A done pulse given together with the last beat returns the controller straight to the armed state.

Top module: `frame_intake_ctrl`

## Requirements
- R1: During and directly after reset, cfg_req and cfg_ready are 1, pkt_ready is 0 and no beat is issued.
- R2: A configuration write is taken only when cfg_valid is high and cfg_ready was high in the previous cycle. The first legal write clears cfg_req and raises pkt_ready one cycle later.
- R3: If cfg_valid stays high for several cycles, only the first cycle's values are taken. The rest are ignored until cfg_valid has gone low.
- R4: A write whose length code is 0 or 7 is taken but discarded. The previous legal set is kept, and cfg_req stays 1 if no legal set exists yet.
- R5: A beat counts only if pkt_ready was high in the previous cycle. While armed, a beat without pkt_sop is dropped.
- R6: A beat in the cycle right after a taken configuration write is dropped.
- R7: A beat in the cycle right after a taken end-of-frame beat is dropped, including one that carries pkt_sop.
- R8: When cfg_valid and pkt_valid count in the same cycle, only the configuration is taken and the beat is dropped.
- R9: Once a frame has started, pkt_ready stays 1 until its last beat is taken, and cfg_ready is 0 for every cycle of the frame after the first.
- R10: Each taken frame beat appears on beat_valid/beat_data one cycle later. beat_idx counts from 0 at the frame start, beat_first marks index 0, and beat_last marks the end-of-frame beat.
- R11: The active set on the cfg_* outputs is loaded from the staged set only when a frame starts. A set taken during a frame applies to the next frame, and frames without a new set reuse the last one.
- R12: Length codes 1 to 6 give act_n = 32 << (code-1), i.e. 32 to 1024. act_crc repeats the 3-bit CRC code (0 off, 1..6 the plain polynomials, 7 masked 24-bit). act_rnti shows the identifier only when act_crc is 7 and reads 0 otherwise.
- R13: After the last beat, cfg_ready and pkt_ready stay 0 until dp_done. A dp_done given with the last beat returns the controller to the armed state in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_len | input | 3 | Length code (1..6 legal) |
| cfg_crc | input | 3 | CRC selection code |
| cfg_ilv | input | 1 | Interleave enable |
| cfg_rnti | input | 16 | Identifier for masked CRC |
| cfg_req | output | 1 | No legal configuration is held yet |
| cfg_ready | output | 1 | Configuration write may be sent next cycle |
| pkt_valid | input | 1 | Packet beat strobe |
| pkt_sop | input | 1 | First beat of a frame |
| pkt_eop | input | 1 | Last beat of a frame |
| pkt_data | input | DATA_W | Beat payload |
| pkt_ready | output | 1 | Beat may be sent next cycle |
| dp_done | input | 1 | Datapath finished the current frame |
| beat_valid | output | 1 | Beat issued to the datapath |
| beat_first | output | 1 | Frame-start strobe |
| beat_last | output | 1 | Final beat of the frame |
| beat_idx | output | IDX_W | Beat index within the frame |
| beat_data | output | DATA_W | Beat payload to the datapath |
| act_len | output | 3 | Active length code |
| act_n | output | 11 | Active code length in bits |
| act_crc | output | 3 | Active CRC selection |
| act_ilv | output | 1 | Active interleave flag |
| act_rnti | output | 16 | Active identifier, zero unless CRC code is 7 |

## Verification
The hardest case to reach is a configuration write taken during a running frame. It can only land in the one cycle after the start beat, where cfg_ready from the previous cycle is still high. That same cycle also carries a beat, which has to be lost. The stimulus sends a start beat, then a write plus a data beat in the next cycle, then a beat that must be dropped, then an end beat that must keep index 1 and the old active set. The following frames then show that the mid-frame set took effect and is reused.

// File: rtl/intake_pkg.sv
package intake_pkg;

    localparam int LEN_W  = 3;
    localparam int CRC_W  = 3;
    localparam int RNTI_W = 16;
    localparam int NBIT_W = 11;

    typedef enum logic [LEN_W-1:0] {
        LEN_NONE = 3'd0,
        LEN_32   = 3'd1,
        LEN_64   = 3'd2,
        LEN_128  = 3'd3,
        LEN_256  = 3'd4,
        LEN_512  = 3'd5,
        LEN_1024 = 3'd6,
        LEN_RSVD = 3'd7
    } len_code_e;

    typedef enum logic [CRC_W-1:0] {
        CRC_NONE   = 3'd0,
        CRC_P24A   = 3'd1,
        CRC_P24B   = 3'd2,
        CRC_P24C   = 3'd3,
        CRC_P16    = 3'd4,
        CRC_P11    = 3'd5,
        CRC_P6     = 3'd6,
        CRC_P24C_M = 3'd7
    } crc_code_e;

    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [CRC_W-1:0]  crc;
        logic              ilv;
        logic [RNTI_W-1:0] rnti;
    } cfg_set_t;

    typedef enum logic [1:0] {
        PH_NOCFG = 2'd0,
        PH_ARMED = 2'd1,
        PH_FRAME = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    function automatic logic len_is_legal(input logic [LEN_W-1:0] code);
        return (code >= LEN_W'(LEN_32)) && (code <= LEN_W'(LEN_1024));
    endfunction

    function automatic logic [NBIT_W-1:0] len_to_bits(input logic [LEN_W-1:0] code);
        logic [LEN_W-1:0] sh;
        sh = code - LEN_W'(1);
        if (!len_is_legal(code))
            return '0;
        return NBIT_W'(32) << sh;
    endfunction

endpackage

// File: rtl/intake_gate.sv
module intake_gate (
    input  logic clk,
    input  logic rst,
    input  logic cfg_valid,
    input  logic pkt_valid,
    input  logic cfg_ready,
    input  logic pkt_ready,
    input  logic eop_taken,
    output logic cfg_take,
    output logic pkt_take
);
    logic cfg_rdy_q;
    logic pkt_rdy_q;
    logic cfg_hold_q;
    logic blank_q;

    always_comb begin
        cfg_take = cfg_valid && cfg_rdy_q && !cfg_hold_q;
        pkt_take = pkt_valid && pkt_rdy_q && !blank_q && !cfg_take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdy_q  <= 1'b0;
            pkt_rdy_q  <= 1'b0;
            cfg_hold_q <= 1'b0;
            blank_q    <= 1'b0;
        end else begin
            cfg_rdy_q <= cfg_ready;
            pkt_rdy_q <= pkt_ready;
            blank_q   <= cfg_take || eop_taken;
            if (cfg_take)
                cfg_hold_q <= 1'b1;
            else if (!cfg_valid)
                cfg_hold_q <= 1'b0;
        end
    end

    assert_cfg_blanks_beat_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_take |=> !pkt_take);
    assert_eop_blanks_beat_R7: assert property (@(posedge clk) disable iff (rst)
        eop_taken |=> !pkt_take);
    assert_held_valid_once_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_take && cfg_valid) |=> !cfg_take);
    assert_beat_needs_ready_R5: assert property (@(posedge clk) disable iff (rst)
        !pkt_ready |=> !pkt_take);

endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import intake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_take,
    input  cfg_set_t cfg_in,
    input  logic     frame_start,
    output logic     cfg_ok,
    output cfg_set_t active
);
    cfg_set_t staged_q;
    cfg_set_t active_q;

    assign cfg_ok = cfg_take && len_is_legal(cfg_in.len);
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
            active_q <= '0;
        end else begin
            if (cfg_ok)
                staged_q <= cfg_in;
            if (frame_start)
                active_q <= staged_q;
        end
    end

    assert_bad_len_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_take && !cfg_ok) |=> $stable(staged_q));
    assert_active_on_start_R11: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(active_q));

endmodule

// File: rtl/phase_fsm.sv
module phase_fsm
    import intake_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_ok,
    input  logic pkt_take,
    input  logic pkt_sop,
    input  logic pkt_eop,
    input  logic dp_done,
    output logic cfg_req,
    output logic cfg_ready,
    output logic pkt_ready,
    output logic frame_start,
    output logic beat_take,
    output logic eop_taken
);
    phase_e ph_q;
    phase_e ph_d;

    always_comb begin
        frame_start = pkt_take && pkt_sop && (ph_q == PH_ARMED);
        beat_take   = frame_start || (pkt_take && (ph_q == PH_FRAME));
        eop_taken   = beat_take && pkt_eop;
        cfg_req     = (ph_q == PH_NOCFG);
        cfg_ready   = (ph_q == PH_NOCFG) || (ph_q == PH_ARMED);
        pkt_ready   = (ph_q == PH_ARMED) || (ph_q == PH_FRAME);
    end

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_NOCFG: if (cfg_ok) ph_d = PH_ARMED;
            PH_ARMED: if (frame_start) ph_d = PH_FRAME;
            PH_FRAME: ;
            PH_DRAIN: if (dp_done) ph_d = PH_ARMED;
            default:  ph_d = PH_NOCFG;
        endcase
        if (eop_taken)
            ph_d = dp_done ? PH_ARMED : PH_DRAIN;
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_NOCFG;
        else     ph_q <= ph_d;
    end

    assert_ready_held_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_FRAME && !eop_taken) |=> pkt_ready);
    assert_req_drops_on_legal_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_req) |-> $past(cfg_ok));
    assert_drain_closed_R13: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_DRAIN && !dp_done) |=> (!cfg_ready && !pkt_ready));

endmodule

// File: rtl/beat_issue.sv
module beat_issue #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_take,
    input  logic              frame_start,
    input  logic              last_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              beat_valid,
    output logic              beat_first,
    output logic              beat_last,
    output logic [IDX_W-1:0]  beat_idx,
    output logic [DATA_W-1:0] beat_data
);
    logic [IDX_W-1:0] next_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_idx_q <= '0;
            beat_valid <= 1'b0;
            beat_first <= 1'b0;
            beat_last  <= 1'b0;
            beat_idx   <= '0;
            beat_data  <= '0;
        end else begin
            beat_valid <= beat_take;
            beat_first <= beat_take && frame_start;
            beat_last  <= beat_take && last_in;
            if (beat_take) begin
                beat_data  <= data_in;
                beat_idx   <= frame_start ? '0 : next_idx_q;
                next_idx_q <= frame_start ? IDX_W'(1) : next_idx_q + IDX_W'(1);
            end
        end
    end

    assert_beat_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        beat_take |=> beat_valid);
    assert_no_stray_beat_R10: assert property (@(posedge clk) disable iff (rst)
        !beat_take |=> !beat_valid);
    assert_first_is_zero_R10: assert property (@(posedge clk) disable iff (rst)
        beat_first |-> (beat_valid && beat_idx == '0));

endmodule

// File: rtl/frame_intake_ctrl.sv
module frame_intake_ctrl
    import intake_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic [2:0]        cfg_len,
    input  logic [2:0]        cfg_crc,
    input  logic              cfg_ilv,
    input  logic [15:0]       cfg_rnti,
    output logic              cfg_req,
    output logic              cfg_ready,
    input  logic              pkt_valid,
    input  logic              pkt_sop,
    input  logic              pkt_eop,
    input  logic [DATA_W-1:0] pkt_data,
    output logic              pkt_ready,
    input  logic              dp_done,
    output logic              beat_valid,
    output logic              beat_first,
    output logic              beat_last,
    output logic [IDX_W-1:0]  beat_idx,
    output logic [DATA_W-1:0] beat_data,
    output logic [2:0]        act_len,
    output logic [10:0]       act_n,
    output logic [2:0]        act_crc,
    output logic              act_ilv,
    output logic [15:0]       act_rnti
);
    logic     cfg_take;
    logic     pkt_take;
    logic     cfg_ok;
    logic     frame_start;
    logic     beat_take;
    logic     eop_taken;
    cfg_set_t cfg_in;
    cfg_set_t active;

    assign cfg_in = '{len: cfg_len, crc: cfg_crc, ilv: cfg_ilv, rnti: cfg_rnti};

    intake_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cfg_valid (cfg_valid),
        .pkt_valid (pkt_valid),
        .cfg_ready (cfg_ready),
        .pkt_ready (pkt_ready),
        .eop_taken (eop_taken),
        .cfg_take  (cfg_take),
        .pkt_take  (pkt_take)
    );

    cfg_store u_store (
        .clk         (clk),
        .rst         (rst),
        .cfg_take    (cfg_take),
        .cfg_in      (cfg_in),
        .frame_start (frame_start),
        .cfg_ok      (cfg_ok),
        .active      (active)
    );

    phase_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cfg_ok      (cfg_ok),
        .pkt_take    (pkt_take),
        .pkt_sop     (pkt_sop),
        .pkt_eop     (pkt_eop),
        .dp_done     (dp_done),
        .cfg_req     (cfg_req),
        .cfg_ready   (cfg_ready),
        .pkt_ready   (pkt_ready),
        .frame_start (frame_start),
        .beat_take   (beat_take),
        .eop_taken   (eop_taken)
    );

    beat_issue #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .beat_take   (beat_take),
        .frame_start (frame_start),
        .last_in     (pkt_eop),
        .data_in     (pkt_data),
        .beat_valid  (beat_valid),
        .beat_first  (beat_first),
        .beat_last   (beat_last),
        .beat_idx    (beat_idx),
        .beat_data   (beat_data)
    );

    always_comb begin
        act_len  = active.len;
        act_n    = len_to_bits(active.len);
        act_crc  = active.crc;
        act_ilv  = active.ilv;
        act_rnti = (active.crc == CRC_W'(CRC_P24C_M)) ? active.rnti : '0;
    end

    assert_cfg_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_take && pkt_valid) |=> !beat_valid);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (cfg_req && cfg_ready && !pkt_ready && !beat_valid));
    assert_legal_length_R12: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (act_n >= 11'd32 && act_n <= 11'd1024 && $countones(act_n) == 1));

endmodule

// File: tb/frame_intake_ctrl_tb_top.sv
module frame_intake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int IW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_valid = 1'b0;
    logic [2:0]    cfg_len = '0;
    logic [2:0]    cfg_crc = '0;
    logic          cfg_ilv = 1'b0;
    logic [15:0]   cfg_rnti = '0;
    logic          cfg_req, cfg_ready;
    logic          pkt_valid = 1'b0, pkt_sop = 1'b0, pkt_eop = 1'b0;
    logic [DW-1:0] pkt_data = '0;
    logic          pkt_ready;
    logic          dp_done = 1'b0;
    logic          beat_valid, beat_first, beat_last;
    logic [IW-1:0] beat_idx;
    logic [DW-1:0] beat_data;
    logic [2:0]    act_len, act_crc;
    logic [10:0]   act_n;
    logic          act_ilv;
    logic [15:0]   act_rnti;

    typedef struct packed {
        logic          first;
        logic          last;
        logic [IW-1:0] idx;
        logic [DW-1:0] data;
    } exp_beat_t;

    exp_beat_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_intake_ctrl #(.DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_valid(cfg_valid), .cfg_len(cfg_len), .cfg_crc(cfg_crc),
        .cfg_ilv(cfg_ilv), .cfg_rnti(cfg_rnti),
        .cfg_req(cfg_req), .cfg_ready(cfg_ready),
        .pkt_valid(pkt_valid), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
        .pkt_data(pkt_data), .pkt_ready(pkt_ready), .dp_done(dp_done),
        .beat_valid(beat_valid), .beat_first(beat_first), .beat_last(beat_last),
        .beat_idx(beat_idx), .beat_data(beat_data),
        .act_len(act_len), .act_n(act_n), .act_crc(act_crc),
        .act_ilv(act_ilv), .act_rnti(act_rnti)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design issues a beat.
    always @(negedge clk) begin
        if (!rst && !finished && beat_valid) begin
            if (exp_q.size() == 0) begin
                check("R5/R6/R7/R8 unexpected beat", {8'h0, beat_data, 14'h0, beat_idx}, 32'hFFFF_FFFF);
            end else begin
                exp_beat_t e;
                e = exp_q.pop_front();
                check("R10 beat", {beat_first, beat_last, beat_idx, beat_data},
                      {e.first, e.last, e.idx, e.data});
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_in();
        cfg_valid = 1'b0;
        pkt_valid = 1'b0; pkt_sop = 1'b0; pkt_eop = 1'b0;
        dp_done   = 1'b0;
    endtask

    task automatic put_cfg(input logic [2:0] l, input logic [2:0] c, input logic i, input logic [15:0] r);
        cfg_valid = 1'b1; cfg_len = l; cfg_crc = c; cfg_ilv = i; cfg_rnti = r;
    endtask

    task automatic put_beat(input logic s, input logic e, input logic [DW-1:0] d, input logic dn);
        pkt_valid = 1'b1; pkt_sop = s; pkt_eop = e; pkt_data = d; dp_done = dn;
    endtask

    task automatic expect_beat(input logic f, input logic l, input int idx, input logic [DW-1:0] d);
        exp_beat_t e;
        e.first = f; e.last = l; e.idx = IW'(idx); e.data = d;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        check("R1 cfg_req in reset", cfg_req, 1);
        rst = 1'b0;
        tick();
        check("R1 cfg_req", cfg_req, 1);
        check("R1 cfg_ready", cfg_ready, 1);
        check("R1 pkt_ready", pkt_ready, 0);

        // R5: beat before any configuration never counts
        put_beat(1, 1, 8'hE1, 0); tick(); clear_in(); tick();
        // R4: illegal length code with no prior set
        put_cfg(3'd0, 3'd1, 0, 16'h0); tick(); clear_in(); tick();
        check("R4 cfg_req kept", cfg_req, 1);
        check("R4 pkt_ready low", pkt_ready, 0);

        // R2/R3: legal set held for three cycles, later cycles carry other values
        put_cfg(3'd2, 3'd7, 1, 16'hABCD); tick();
        put_cfg(3'd5, 3'd2, 0, 16'h1111); tick();
        check("R2 cfg_req cleared", cfg_req, 0);
        check("R2 pkt_ready raised", pkt_ready, 1);
        put_cfg(3'd6, 3'd3, 0, 16'h2222); tick();
        clear_in(); tick();
        // R5: armed, beat without sop dropped
        put_beat(0, 0, 8'hE2, 0); tick();
        // three-beat frame
        put_beat(1, 0, 8'h10, 0); expect_beat(1, 0, 0, 8'h10); tick();
        check("R9 cfg_ready low in frame", cfg_ready, 0);
        check("R9 pkt_ready held", pkt_ready, 1);
        put_beat(0, 0, 8'h11, 0); expect_beat(0, 0, 1, 8'h11); tick();
        check("R9 pkt_ready held mid", pkt_ready, 1);
        put_beat(0, 1, 8'h12, 0); expect_beat(0, 1, 2, 8'h12); tick();
        clear_in();
        check("R13 pkt_ready closed", pkt_ready, 0);
        check("R13 cfg_ready closed", cfg_ready, 0);
        check("R3/R12 act_n", act_n, 64);
        check("R12 act_crc", act_crc, 7);
        check("R12 act_rnti masked mode", act_rnti, 16'hABCD);
        check("R11 act_ilv", act_ilv, 1);
        tick();
        put_beat(1, 1, 8'hE3, 0); tick(); clear_in();   // draining: must not count
        dp_done = 1'b1; tick(); clear_in(); tick();
        check("R13 re-armed", pkt_ready, 1);

        // R6, R13 fast return, R7
        put_cfg(3'd3, 3'd1, 0, 16'h1234); tick(); clear_in();
        put_beat(1, 0, 8'hE4, 0); tick();                 // R6 dropped
        put_beat(1, 1, 8'h22, 1); expect_beat(1, 1, 0, 8'h22); tick();
        check("R13 armed after done with last", pkt_ready, 1);
        check("R13 cfg_ready after done with last", cfg_ready, 1);
        put_beat(1, 1, 8'hE5, 0); tick();                 // R7 dropped
        put_beat(1, 1, 8'h44, 0); expect_beat(1, 1, 0, 8'h44); tick();
        clear_in();
        check("R12 act_n 128", act_n, 128);
        check("R12 act_rnti zero", act_rnti, 16'h0);
        dp_done = 1'b1; tick(); clear_in(); tick();

        // R8 while armed
        put_cfg(3'd6, 3'd3, 1, 16'h5555); put_beat(1, 0, 8'hE6, 0); tick();
        clear_in(); put_beat(1, 0, 8'hE7, 0); tick();      // blanked by R6
        put_beat(1, 0, 8'h50, 0); expect_beat(1, 0, 0, 8'h50); tick();
        // R8 mid-frame: write wins over the data beat
        clear_in(); put_cfg(3'd1, 3'd4, 0, 16'h7777); put_beat(0, 0, 8'hE8, 0); tick();
        clear_in(); put_beat(0, 0, 8'hE9, 0); tick();      // blanked by R6
        put_beat(0, 1, 8'h51, 1); expect_beat(0, 1, 1, 8'h51); tick();
        clear_in();
        check("R11 mid-frame set not active", act_n, 1024);
        check("R11 act_crc old", act_crc, 3);
        tick();
        put_beat(1, 1, 8'h60, 1); expect_beat(1, 1, 0, 8'h60); tick(); clear_in(); tick();
        check("R11 next frame uses new set", act_n, 32);
        check("R11 act_crc new", act_crc, 4);
        // R11 reuse without fresh set
        put_beat(1, 1, 8'h61, 1); expect_beat(1, 1, 0, 8'h61); tick(); clear_in(); tick();
        check("R11 reuse", act_n, 32);
        // R4 illegal code 7 with prior set
        put_cfg(3'd7, 3'd6, 1, 16'h0); tick(); clear_in(); tick();
        put_beat(1, 1, 8'h62, 1); expect_beat(1, 1, 0, 8'h62); tick(); clear_in(); tick();
        check("R4 act_n kept", act_n, 32);
        check("R4 act_crc kept", act_crc, 4);
        check("R4 cfg_req stays low", cfg_req, 0);

        repeat (3) tick();
        check("R10 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule